// File: doc/BRIEF.md
# I2C Target Front End

This block is the bus-facing half of an I2C target. It samples the open-drain SCL and SDA lines with the system clock. A glitch filter rejects short pulses on both lines. From the filtered lines the block finds START, repeated START and STOP conditions and keeps a bus-busy flag. It then runs a bit-level engine that decodes the address byte, acknowledges a match and moves data bytes in either direction.

The host logic sees a byte-wide handshake. In receive direction the block pulses `rx_byte_p` with the byte on `rx_data`, and the host answers with `rx_take`. In transmit direction the block pulses `tx_need_p`, and the host answers with `tx_load` and the byte on `tx_data`. When the host is late, the block holds SCL low until the host answers.

Any START or repeated START sends the engine back to address reception, wherever the transfer stands. A malformed bus sequence therefore cannot strand it. The block compares addresses against a static own-address input. That input is taken in only while the bus is idle.

Top module: `i2c_target_fe`

## Requirements
- R1: Each bus line takes a new filtered level only when two consecutive synchronized samples agree. A low pulse of one system-clock sample on SDA, with SCL high, produces no START, no STOP and no change of `bus_busy`.
- R2: `bus_busy` goes to 1 after a START (SDA falling while SCL is high) and to 0 after a STOP (SDA rising while SCL is high), whether or not any address matched. It is 0 after reset, and `scl_oe` and `sda_oe` are 0 after reset.
- R3: A START or repeated START returns the engine to address reception, even in the middle of an address or data byte. The next full address byte is decoded normally.
- R4: The address byte is seven address bits, MSB first, followed by the direction bit (0 = controller writes, 1 = controller reads). When the seven bits equal the latched own address, the block acknowledges by driving SDA low during the ninth clock and pulses `addr_hit_p`. On a mismatch it does not acknowledge and produces no data pulses until the next START.
- R5: When `gc_en` is 1, a write to address 0x00 is acknowledged and pulses `gc_p` together with `addr_hit_p`. When `gc_en` is 0, or the direction bit is 1, address 0x00 is not acknowledged.
- R6: In receive direction each byte is sampled MSB first on rising SCL. The block pulses `rx_byte_p` with the byte on `rx_data` and acknowledges it.
- R7: If a received byte has not been taken with `rx_take` by the falling SCL edge after its eighth bit, the block holds SCL low until `rx_take` arrives. It then acknowledges the byte.
- R8: In transmit direction the block pulses `tx_need_p` when it matches a read address, and again after each byte the controller acknowledges. It shifts the loaded byte out MSB first and changes `sda_oe` only while the filtered SCL is low.
- R9: If no byte has been loaded when a transmit byte must start, the block holds SCL low until `tx_load` arrives.
- R10: A NACK (SDA high in the ninth clock) from the controller after a transmit byte ends the transfer. SDA stays released and no further `tx_need_p` pulses occur until the next START.
- R11: A change of `own_addr` while `bus_busy` is 1 is ignored. The new value takes effect only after the bus becomes idle.
- R12: After a short, filter-passing low pulse on SDA while the bus is idle, the block still acknowledges a later correctly addressed transfer.
- R13: Every STOP produces a one-cycle `stop_p` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| own_addr | input | 7 | Own 7-bit target address, changed only while the bus is idle |
| gc_en | input | 1 | Enable response to the general-call address |
| bus_busy | output | 1 | 1 between a START and the following STOP |
| addr_hit_p | output | 1 | Pulse: own or general-call address matched |
| gc_p | output | 1 | Pulse: general-call address matched |
| rx_data | output | 8 | Last received data byte |
| rx_byte_p | output | 1 | Pulse: new byte on rx_data |
| rx_take | input | 1 | Host has consumed rx_data |
| tx_data | input | 8 | Byte to transmit, valid with tx_load |
| tx_load | input | 1 | Host supplies tx_data |
| tx_need_p | output | 1 | Pulse: a transmit byte is needed |
| stop_p | output | 1 | Pulse: STOP seen |

## Verification
The bench sweeps all 128 write addresses with general call enabled. It expects exactly the own address and 0x00 to be acknowledged. An engine with a wrong comparison or bit order would acknowledge the wrong target. It cuts address and data bytes short with repeated STARTs. A design that kept its bit count across the restart would then misread the next address. It also sends one-sample and three-sample SDA pulses on an idle bus. A filter that is too weak would see a false START, and an engine that locks up would stop acknowledging. Finally, it delays the host handshake in both directions. The bench measures how long SCL is held low and checks that the own address is frozen while busy. A design without stretching would drop bytes, and one without the freeze would answer a different address mid-transfer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int ADDR_W = 7;
   localparam int DATA_W = 8;
   localparam int CNT_W  = $clog2(DATA_W);
   localparam logic [ADDR_W-1:0] GC_ADDR = '0;

   typedef enum logic [3:0] {
      E_IDLE,
      E_ADDR,
      E_AEND,
      E_AACK,
      E_RX,
      E_REND,
      E_RHOLD,
      E_RACK,
      E_TWAIT,
      E_TX,
      E_TACK,
      E_SKIP
   } eng_st_t;
endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
   parameter int SYNC_LEN = 2,
   parameter int FILT_LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   logic [SYNC_LEN-1:0] sync_q;
   logic [FILT_LEN-1:0] win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         win_q  <= '1;
         line_o <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
         win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
         // accept a level only when the whole window agrees
         if (&win_q)
            line_o <= 1'b1;
         else if (~|win_q)
            line_o <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_busy
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         bus_busy <= 1'b0;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
         if (start_det)
            bus_busy <= 1'b1;
         else if (stop_det)
            bus_busy <= 1'b0;
      end
   end

   always_comb begin
      start_det = scl_f && scl_q && sda_q && !sda_f;
      stop_det  = scl_f && scl_q && !sda_q && sda_f;
      scl_rise  = scl_f && !scl_q;
      scl_fall  = !scl_f && scl_q;
   end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_f,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [ADDR_W-1:0] addr_lat,
   input  logic              gc_en,
   input  logic              rx_take,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_load,
   output logic              scl_hold,
   output logic              sda_low,
   output logic              addr_hit_p,
   output logic              gc_p,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_byte_p,
   output logic              tx_need_p,
   output logic              stop_p
);
   eng_st_t           st;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] tx_buf;
   logic [CNT_W-1:0]  bitcnt;
   logic              rd_dir;
   logic              rx_pend;
   logic              tx_full;
   logic              nack_q;
   logic              own_hit;
   logic              gc_hit;
   logic              last_bit;

   always_comb begin
      own_hit  = (shreg[ADDR_W-1:0] == addr_lat);
      gc_hit   = gc_en && !sda_f && (shreg[ADDR_W-1:0] == GC_ADDR);
      last_bit = (bitcnt == CNT_W'(DATA_W-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= E_IDLE;
         shreg      <= '0;
         tx_buf     <= '0;
         bitcnt     <= '0;
         rd_dir     <= 1'b0;
         rx_pend    <= 1'b0;
         tx_full    <= 1'b0;
         nack_q     <= 1'b0;
         rx_data    <= '0;
         addr_hit_p <= 1'b0;
         gc_p       <= 1'b0;
         rx_byte_p  <= 1'b0;
         tx_need_p  <= 1'b0;
         stop_p     <= 1'b0;
      end else begin
         addr_hit_p <= 1'b0;
         gc_p       <= 1'b0;
         rx_byte_p  <= 1'b0;
         tx_need_p  <= 1'b0;
         stop_p     <= 1'b0;
         if (rx_take)
            rx_pend <= 1'b0;
         if (tx_load) begin
            tx_buf  <= tx_data;
            tx_full <= 1'b1;
         end

         if (start_det) begin
            // any START restarts address reception
            st      <= E_ADDR;
            bitcnt  <= '0;
            tx_full <= 1'b0;
         end else if (stop_det) begin
            st     <= E_IDLE;
            stop_p <= 1'b1;
         end else begin
            unique case (st)
               E_ADDR: if (scl_rise) begin
                  shreg  <= {shreg[DATA_W-2:0], sda_f};
                  bitcnt <= bitcnt + 1'b1;
                  if (last_bit) begin
                     if ((own_hit || gc_hit) && !(sda_f && !own_hit)) begin
                        st         <= E_AEND;
                        rd_dir     <= sda_f;
                        addr_hit_p <= 1'b1;
                        gc_p       <= gc_hit;
                        tx_need_p  <= sda_f;
                     end else begin
                        st <= E_SKIP;
                     end
                  end
               end
               E_AEND: if (scl_fall) st <= E_AACK;
               E_AACK: if (scl_fall) begin
                  bitcnt <= '0;
                  if (!rd_dir)
                     st <= E_RX;
                  else if (tx_full) begin
                     shreg   <= tx_buf;
                     tx_full <= 1'b0;
                     st      <= E_TX;
                  end else
                     st <= E_TWAIT;
               end
               E_RX: if (scl_rise) begin
                  shreg  <= {shreg[DATA_W-2:0], sda_f};
                  bitcnt <= bitcnt + 1'b1;
                  if (last_bit) begin
                     rx_data   <= {shreg[DATA_W-2:0], sda_f};
                     rx_byte_p <= 1'b1;
                     rx_pend   <= 1'b1;
                     st        <= E_REND;
                  end
               end
               E_REND: if (scl_fall) st <= rx_pend ? E_RHOLD : E_RACK;
               E_RHOLD: if (!rx_pend) st <= E_RACK;
               E_RACK: if (scl_fall) begin
                  bitcnt <= '0;
                  st     <= E_RX;
               end
               E_TWAIT: if (tx_full) begin
                  shreg   <= tx_buf;
                  tx_full <= 1'b0;
                  bitcnt  <= '0;
                  st      <= E_TX;
               end
               E_TX: if (scl_fall) begin
                  if (last_bit)
                     st <= E_TACK;
                  else begin
                     shreg  <= {shreg[DATA_W-2:0], 1'b0};
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
               E_TACK: begin
                  if (scl_rise) begin
                     nack_q    <= sda_f;
                     tx_need_p <= !sda_f;
                  end else if (scl_fall) begin
                     bitcnt <= '0;
                     if (nack_q)
                        st <= E_SKIP;
                     else if (tx_full) begin
                        shreg   <= tx_buf;
                        tx_full <= 1'b0;
                        st      <= E_TX;
                     end else
                        st <= E_TWAIT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      scl_hold = (st == E_RHOLD) || (st == E_TWAIT);
      sda_low  = (st == E_AACK) || (st == E_RACK) ||
                 ((st == E_TX) && !shreg[DATA_W-1]);
   end
endmodule

// File: rtl/i2c_target_fe.sv
module i2c_target_fe
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_LEN = 2,
   parameter int FILT_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_en,
   output logic              bus_busy,
   output logic              addr_hit_p,
   output logic              gc_p,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_byte_p,
   input  logic              rx_take,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_load,
   output logic              tx_need_p,
   output logic              stop_p
);
   localparam int NLINES = 2;

   initial begin
      assert (SYNC_LEN >= 2 && SYNC_LEN <= 4)
         else $error("SYNC_LEN must lie in 2..4");
      assert (FILT_LEN >= 2 && FILT_LEN <= 8)
         else $error("FILT_LEN must lie in 2..8");
      assert (DATA_W == ADDR_W + 1)
         else $error("address plus direction bit must fill one byte");
   end

   logic [NLINES-1:0] raw_lines;
   logic [NLINES-1:0] filt_lines;
   logic              scl_f, sda_f;
   logic              start_det, stop_det, scl_rise, scl_fall;
   logic [ADDR_W-1:0] addr_lat;

   assign raw_lines = {sda_i, scl_i};

   for (genvar gi = 0; gi < NLINES; gi++) begin : g_filt
      i2c_tgt_filt #(
         .SYNC_LEN(SYNC_LEN),
         .FILT_LEN(FILT_LEN)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(raw_lines[gi]),
         .line_o(filt_lines[gi])
      );
   end

   assign scl_f = filt_lines[0];
   assign sda_f = filt_lines[1];

   i2c_tgt_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (scl_f),
      .sda_f    (sda_f),
      .start_det(start_det),
      .stop_det (stop_det),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .bus_busy (bus_busy)
   );

   // own address is sampled only while the bus is idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_lat <= '0;
      else if (!bus_busy)
         addr_lat <= own_addr;
   end

   i2c_tgt_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_f     (sda_f),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .addr_lat  (addr_lat),
      .gc_en     (gc_en),
      .rx_take   (rx_take),
      .tx_data   (tx_data),
      .tx_load   (tx_load),
      .scl_hold  (scl_oe),
      .sda_low   (sda_oe),
      .addr_hit_p(addr_hit_p),
      .gc_p      (gc_p),
      .rx_data   (rx_data),
      .rx_byte_p (rx_byte_p),
      .tx_need_p (tx_need_p),
      .stop_p    (stop_p)
   );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
   import i2c_tgt_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              scl_f,
   input logic              scl_oe,
   input logic              sda_oe,
   input logic              bus_busy,
   input logic              stop_p,
   input logic              addr_hit_p,
   input logic              gc_p,
   input logic [ADDR_W-1:0] addr_lat
);
   AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |-> !bus_busy); // R2

   AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_f); // R8

   AST_STRETCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> !scl_f); // R7

   AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_busy && $past(bus_busy)) |-> $stable(addr_lat)); // R11

   AST_GC_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      gc_p |-> addr_hit_p); // R5
endmodule

bind i2c_target_fe i2c_tgt_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_f     (scl_f),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .bus_busy  (bus_busy),
   .stop_p    (stop_p),
   .addr_hit_p(addr_hit_p),
   .gc_p      (gc_p),
   .addr_lat  (addr_lat)
);

// File: tb/sim_i2c_target_fe.sv
`timescale 1ns/1ps
module sim_i2c_target_fe;
   localparam int H   = 20;
   localparam int HLD = 8;
   localparam logic [6:0] OWN = 7'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl_lo = 1'b0, m_sda_lo = 1'b0;
   logic       scl_line, sda_line;
   logic       scl_oe, sda_oe;
   logic [6:0] own_addr = OWN;
   logic       gc_en = 1'b1;
   logic       bus_busy, addr_hit_p, gc_p, rx_byte_p, tx_need_p, stop_p;
   logic [7:0] rx_data;
   logic       rx_take = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_load = 1'b0;

   int n_chk = 0, n_bad = 0;
   int cyc = 0, take_cyc = -1, load_cyc = -1;
   logic [7:0] man_tx = 8'h00;
   logic auto_rx = 1'b1, auto_tx = 1'b1;
   logic [7:0] rx_log [0:63];
   logic [7:0] tx_src [0:7];
   int rx_n = 0, tx_i = 0;
   int cnt_hit = 0, cnt_gc = 0, cnt_rx = 0, cnt_need = 0, cnt_stop = 0, cnt_busy = 0;
   logic busy_prev = 1'b0;
   int last_wait = 0;

   always #4 clk = ~clk;

   assign scl_line = !(m_scl_lo || scl_oe);
   assign sda_line = !(m_sda_lo || sda_oe);

   i2c_target_fe u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .gc_en(gc_en),
      .bus_busy(bus_busy), .addr_hit_p(addr_hit_p), .gc_p(gc_p),
      .rx_data(rx_data), .rx_byte_p(rx_byte_p), .rx_take(rx_take),
      .tx_data(tx_data), .tx_load(tx_load), .tx_need_p(tx_need_p),
      .stop_p(stop_p)
   );

   // host model and pulse monitor, away from the active edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (addr_hit_p) cnt_hit = cnt_hit + 1;
      if (gc_p) cnt_gc = cnt_gc + 1;
      if (tx_need_p) cnt_need = cnt_need + 1;
      if (stop_p) cnt_stop = cnt_stop + 1;
      if (bus_busy && !busy_prev) cnt_busy = cnt_busy + 1;
      busy_prev = bus_busy;
      if (rx_byte_p) begin
         cnt_rx = cnt_rx + 1;
         rx_log[rx_n[5:0]] = rx_data;
         rx_n = rx_n + 1;
      end
      rx_take = (auto_rx && rx_byte_p) || (cyc == take_cyc);
      if (auto_tx && tx_need_p) begin
         tx_data = tx_src[tx_i[2:0]];
         tx_i    = tx_i + 1;
         tx_load = 1'b1;
      end else if (cyc == load_cyc) begin
         tx_data = man_tx;
         tx_load = 1'b1;
      end else
         tx_load = 1'b0;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_high();
      last_wait = 0;
      while (!scl_line) begin
         @(negedge clk);
         last_wait++;
      end
   endtask

   task automatic bus_start();
      m_sda_lo = 1'b1; wt(H);
      m_scl_lo = 1'b1; wt(HLD);
   endtask

   task automatic bus_rstart();
      m_sda_lo = 1'b0; wt(H);
      m_scl_lo = 1'b0; wait_high(); wt(H);
      m_sda_lo = 1'b1; wt(H);
      m_scl_lo = 1'b1; wt(HLD);
   endtask

   task automatic bus_stop();
      m_sda_lo = 1'b1; wt(H);
      m_scl_lo = 1'b0; wait_high(); wt(H);
      m_sda_lo = 1'b0; wt(H);
   endtask

   task automatic wbit(input bit b);
      m_sda_lo = !b; wt(H);
      m_scl_lo = 1'b0; wait_high(); wt(H);
      m_scl_lo = 1'b1; wt(HLD);
   endtask

   task automatic rbit(output bit b);
      m_sda_lo = 1'b0; wt(H);
      m_scl_lo = 1'b0; wait_high(); wt(H/2);
      b = sda_line; wt(H/2);
      m_scl_lo = 1'b1; wt(HLD);
   endtask

   task automatic wbyte(input logic [7:0] v, output bit ack);
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      rbit(ack);
   endtask

   task automatic rbyte(output logic [7:0] v, input bit nack, output int first_wait);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         v[i] = b;
         if (i == 7) first_wait = last_wait;
      end
      wbit(nack);
   endtask

   initial begin
      bit ack, b;
      logic [7:0] d;
      int fw, base_rx, base_need, base_stop, base_busy, base_gc, base_hit;
      tx_src[0] = 8'hA5; tx_src[1] = 8'h3C; tx_src[2] = 8'hF0;
      for (int i = 3; i < 8; i++) tx_src[i] = 8'h00;

      wt(5);
      chk(bus_busy == 1'b0, "R2 reset busy", bus_busy, 0);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R2 reset oe", {scl_oe, sda_oe}, 0);
      rst_n = 1'b1;
      wt(10);

      // R4 R5 sweep of all write addresses
      for (int a = 0; a < 128; a++) begin
         bit exp_ack;
         exp_ack = (a == int'(OWN)) || (a == 0);
         bus_start();
         wbyte({a[6:0], 1'b0}, ack);
         chk(ack == !exp_ack, "R4 address sweep ack", a * 2 + ack, a * 2 + !exp_ack);
         bus_stop();
      end
      wt(10);
      chk(cnt_hit == 2, "R4 sweep hit count", cnt_hit, 2);
      chk(cnt_gc == 1, "R5 sweep general-call count", cnt_gc, 1);
      chk(cnt_stop == 128, "R13 stop pulse count", cnt_stop, 128);
      chk(bus_busy == 1'b0, "R2 busy after stop", bus_busy, 0);

      // R5 general call disabled, and read to 0x00
      base_gc = cnt_gc;
      gc_en = 1'b0;
      bus_start(); wbyte(8'h00, ack); bus_stop();
      chk(ack == 1'b1, "R5 gc disabled nack", ack, 1);
      gc_en = 1'b1;
      bus_start(); wbyte(8'h01, ack); bus_stop();
      chk(ack == 1'b1, "R5 gc read nack", ack, 1);
      chk(cnt_gc == base_gc, "R5 no gc pulse", cnt_gc, base_gc);

      // R6 receive sweep of patterns
      base_rx = rx_n;
      bus_start(); wbyte({OWN, 1'b0}, ack);
      chk(ack == 1'b0, "R4 own write ack", ack, 0);
      chk(bus_busy == 1'b1, "R2 busy during transfer", bus_busy, 1);
      for (int k = 0; k < 16; k++) begin
         logic [7:0] v;
         v = 8'(k * 37 + 5) ^ {k[3:0], k[3:0]};
         wbyte(v, ack);
         chk(ack == 1'b0, "R6 data ack", ack, 0);
         chk(rx_log[6'(base_rx + k)] == v, "R6 data value", rx_log[6'(base_rx + k)], v);
      end
      bus_stop();

      // R4 mismatch: no data pulses
      base_rx = cnt_rx;
      bus_start(); wbyte({7'h15, 1'b0}, ack);
      chk(ack == 1'b1, "R4 mismatch nack", ack, 1);
      wbyte(8'h00, ack);
      chk(ack == 1'b1 && cnt_rx == base_rx, "R4 no data after mismatch", cnt_rx, base_rx);
      bus_stop();

      // R7 receive stretch
      auto_rx = 1'b0;
      bus_start(); wbyte({OWN, 1'b0}, ack);
      for (int i = 7; i >= 0; i--) wbit(logic'(8'h96 >> i));
      chk(rx_data == 8'h96, "R7 rx data before take", rx_data, 8'h96);
      take_cyc = cyc + 300;
      rbit(ack);
      chk(last_wait >= 250, "R7 scl held until take", last_wait, 250);
      chk(ack == 1'b0, "R7 ack after take", ack, 0);
      bus_stop();
      auto_rx = 1'b1;

      // R8 R10 transmit
      base_need = cnt_need;
      bus_start(); wbyte({OWN, 1'b1}, ack);
      chk(ack == 1'b0, "R8 read address ack", ack, 0);
      rbyte(d, 1'b0, fw); chk(d == 8'hA5, "R8 tx byte 0", d, 8'hA5);
      rbyte(d, 1'b0, fw); chk(d == 8'h3C, "R8 tx byte 1", d, 8'h3C);
      rbyte(d, 1'b1, fw); chk(d == 8'hF0, "R8 tx byte 2", d, 8'hF0);
      rbit(b);
      chk(b == 1'b1, "R10 sda released after nack", b, 1);
      chk(cnt_need - base_need == 3, "R10 need count", cnt_need - base_need, 3);
      bus_stop();

      // R9 transmit stretch
      auto_tx = 1'b0;
      bus_start(); wbyte({OWN, 1'b1}, ack);
      man_tx = 8'h69;
      load_cyc = cyc + 300;
      rbyte(d, 1'b1, fw);
      chk(fw >= 250, "R9 scl held until load", fw, 250);
      chk(d == 8'h69, "R9 late byte value", d, 8'h69);
      bus_stop();
      auto_tx = 1'b1;

      // R3 restart in mid byte
      base_rx = cnt_rx;
      bus_start();
      for (int i = 7; i >= 4; i--) wbit(logic'(8'h54 >> i));
      bus_rstart();
      wbyte({OWN, 1'b0}, ack);
      chk(ack == 1'b0, "R3 ack after mid-address restart", ack, 0);
      for (int i = 7; i >= 5; i--) wbit(logic'(8'h77 >> i));
      bus_rstart();
      wbyte({OWN, 1'b0}, ack);
      chk(ack == 1'b0, "R3 ack after mid-data restart", ack, 0);
      wbyte(8'h11, ack);
      chk(cnt_rx - base_rx == 1, "R3 one byte received", cnt_rx - base_rx, 1);
      chk(rx_log[6'(rx_n - 1)] == 8'h11, "R3 byte value", rx_log[6'(rx_n - 1)], 8'h11);
      bus_stop();

      // R11 own address frozen while busy
      bus_start(); wbyte({OWN, 1'b0}, ack);
      own_addr = 7'h11;
      bus_rstart(); wbyte({7'h11, 1'b0}, ack);
      chk(ack == 1'b1, "R11 new address ignored while busy", ack, 1);
      bus_rstart(); wbyte({OWN, 1'b0}, ack);
      chk(ack == 1'b0, "R11 old address still active", ack, 0);
      bus_stop(); wt(10);
      bus_start(); wbyte({7'h11, 1'b0}, ack); bus_stop();
      chk(ack == 1'b0, "R11 new address after idle", ack, 0);
      own_addr = OWN; wt(10);

      // R1 R12 glitches on idle SDA
      base_stop = cnt_stop; base_busy = cnt_busy;
      m_sda_lo = 1'b1; wt(1); m_sda_lo = 1'b0; wt(20);
      chk(cnt_busy == base_busy && cnt_stop == base_stop, "R1 one-sample glitch rejected",
          cnt_busy - base_busy, 0);
      m_sda_lo = 1'b1; wt(3); m_sda_lo = 1'b0; wt(20);
      chk(cnt_stop == base_stop + 1, "R1 three-sample pulse seen", cnt_stop - base_stop, 1);
      chk(cnt_busy == base_busy + 1 && bus_busy == 1'b0, "R2 busy tracks pulse",
          cnt_busy - base_busy, 1);
      base_hit = cnt_hit;
      bus_start(); wbyte({OWN, 1'b0}, ack); bus_stop();
      chk(ack == 1'b0 && cnt_hit == base_hit + 1, "R12 ack after idle pulse", ack, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule